// File: doc/BRIEF.md
# Byte-Bus GPIO Port with Edge Interrupts

An eight-pin general-purpose I/O port that sits on a byte-wide peripheral register bus. Software sets each pin's output level, its drive enable and its pull resistor enable. Software reads the pin levels after they pass through a two-flop synchronizer. A two-bit function code per pin routes the pad to plain I/O, to a primary peripheral or to a secondary peripheral. One code is reserved and leaves the pad undriven.

Every pin has a pending flag. The flag is set by the rising or the falling edge of the synchronized level, and a per-pin polarity bit chooses which. The flags are gated by per-pin enables and merged into one registered port interrupt request. A pin assigned to a peripheral cannot raise that request.

A synchronous reset clears the whole block. A separate power-up-clear input clears the control registers but keeps the edge polarity register.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads 0, `irq` is 0, and `pad_oe` and `pad_out` are 0.
- R2: With function code 00 (I/O), `pad_oe[i]` follows direction bit i (1 = output) and `pad_out[i]` follows output bit i. Both change one cycle after the write.
- R3: The input register (address 0x20) returns `pin_in` after two synchronizer stages. Writes to it are ignored.
- R4: With polarity bit 0, a 0-to-1 change of the synchronized pin sets flag bit i (address 0x23). A 1-to-0 change does not set it.
- R5: With polarity bit 1 (address 0x24), a 1-to-0 change sets the flag and a 0-to-1 change does not.
- R6: `irq` is the registered OR over the pins of (flag AND enable AND NOT select bit). The enable register is at 0x25 and the select bit is at 0x26.
- R7: A bus write to the flag register loads it, so a 1 sets a flag and a 0 clears it. If a hardware edge falls in the same cycle as a write of 0, the flag stays set.
- R8: The function code is {second select (0x41), select (0x26)}. Code 01 drives `pad_out` from `pri_out` and passes the synchronized level to `pri_in`. Code 11 drives `pad_out` from `sec_out` and passes the level to `sec_in`. In both codes `pad_oe` still follows the direction bit. Code 10 is reserved: it forces `pad_oe` and `pad_out` to 0 and routes nothing.
- R9: A `puc` pulse clears the output (0x21), direction (0x22), flag, enable, select, second select and resistor enable (0x27) registers. The polarity register keeps its value.
- R10: The resistor enable register reads back what was written, and `pull_en` equals it.
- R11: Writing the polarity register does not by itself set any flag.
- R12: Reads of an unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the whole block |
| puc | input | 1 | Power-up-clear; clears the control register subset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, registered, valid the cycle after the address |
| pin_in | input | WIDTH | Asynchronous pad levels |
| pad_out | output | WIDTH | Registered pad drive value |
| pad_oe | output | WIDTH | Registered pad drive enable |
| pull_en | output | WIDTH | Pull resistor enable per pin |
| pri_out | input | WIDTH | Primary peripheral drive values |
| sec_out | input | WIDTH | Secondary peripheral drive values |
| pri_in | output | WIDTH | Synchronized levels of pins in primary mode |
| sec_in | output | WIDTH | Synchronized levels of pins in secondary mode |
| irq | output | 1 | Port interrupt request |

## Verification
A hardware edge and a software write to the flag register can land on the same clock edge. The bench provokes this by changing a pin exactly two cycles before a write of zero to the flags, so the synchronized edge is seen on the same edge that the write takes effect. It then judges the outcome by reading the flag back and expecting the bit still set. The same clash between `puc` and a pending edge is covered by a property that requires every flag to be clear one cycle after power-up-clear.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Per-pin function code: {second select, select}
  typedef enum logic [1:0] {
    FN_IO  = 2'b00,
    FN_PRI = 2'b01,
    FN_RSV = 2'b10,
    FN_SEC = 2'b11
  } pin_fn_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_det
    logic rise, fall;
    assign rise     = lvl_i[i] & ~prev_q[i];
    assign fall     = ~lvl_i[i] & prev_q[i];
    assign hit_o[i] = pol_i[i] ? fall : rise;
  end
endmodule

// File: rtl/gpio_mux.sv
module gpio_mux
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] sel_i,
  input  logic [W-1:0] sel2_i,
  input  logic [W-1:0] out_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] pri_out_i,
  input  logic [W-1:0] sec_out_i,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] drv_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] pri_in_o,
  output logic [W-1:0] sec_in_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    pin_fn_e fn;
    logic    d, e, pi, si;
    assign fn = pin_fn_e'({sel2_i[i], sel_i[i]});

    always_comb begin
      d  = 1'b0;
      e  = 1'b0;
      pi = 1'b0;
      si = 1'b0;
      unique case (fn)
        FN_IO:  begin d = out_i[i];     e = dir_i[i]; end
        FN_PRI: begin d = pri_out_i[i]; e = dir_i[i]; pi = lvl_i[i]; end
        FN_SEC: begin d = sec_out_i[i]; e = dir_i[i]; si = lvl_i[i]; end
        default: ;
      endcase
    end

    assign drv_o[i]    = d;
    assign oe_o[i]     = e;
    assign pri_in_o[i] = pi;
    assign sec_in_o[i] = si;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int unsigned          WIDTH    = 8,
  parameter int unsigned          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]    ADR_IN   = 'h20,
  parameter logic [ADDR_W-1:0]    ADR_OUT  = 'h21,
  parameter logic [ADDR_W-1:0]    ADR_DIR  = 'h22,
  parameter logic [ADDR_W-1:0]    ADR_FLAG = 'h23,
  parameter logic [ADDR_W-1:0]    ADR_POL  = 'h24,
  parameter logic [ADDR_W-1:0]    ADR_IEN  = 'h25,
  parameter logic [ADDR_W-1:0]    ADR_SEL  = 'h26,
  parameter logic [ADDR_W-1:0]    ADR_PULL = 'h27,
  parameter logic [ADDR_W-1:0]    ADR_SEL2 = 'h41
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              puc,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pull_en,
  input  logic [WIDTH-1:0]  pri_out,
  input  logic [WIDTH-1:0]  sec_out,
  output logic [WIDTH-1:0]  pri_in,
  output logic [WIDTH-1:0]  sec_in,
  output logic              irq
);
  logic [WIDTH-1:0] out_q, dir_q, flag_q, pol_q, ien_q, sel_q, sel2_q, pull_q;
  logic [WIDTH-1:0] lvl, edge_hit;
  logic [WIDTH-1:0] mux_drv, mux_oe, mux_pri, mux_sec;
  logic [WIDTH-1:0] rd_mux;

  logic wr_out, wr_dir, wr_flag, wr_pol, wr_ien, wr_sel, wr_sel2, wr_pull;
  assign wr_out  = bus_we && (bus_addr == ADR_OUT);
  assign wr_dir  = bus_we && (bus_addr == ADR_DIR);
  assign wr_flag = bus_we && (bus_addr == ADR_FLAG);
  assign wr_pol  = bus_we && (bus_addr == ADR_POL);
  assign wr_ien  = bus_we && (bus_addr == ADR_IEN);
  assign wr_sel  = bus_we && (bus_addr == ADR_SEL);
  assign wr_sel2 = bus_we && (bus_addr == ADR_SEL2);
  assign wr_pull = bus_we && (bus_addr == ADR_PULL);

  gpio_sync #(.W(WIDTH)) u_sync (
    .clk(clk), .rst(rst), .async_i(pin_in), .sync_o(lvl)
  );

  gpio_edge #(.W(WIDTH)) u_edge (
    .clk(clk), .rst(rst), .lvl_i(lvl), .pol_i(pol_q), .hit_o(edge_hit)
  );

  gpio_mux #(.W(WIDTH)) u_mux (
    .sel_i(sel_q), .sel2_i(sel2_q), .out_i(out_q), .dir_i(dir_q),
    .pri_out_i(pri_out), .sec_out_i(sec_out), .lvl_i(lvl),
    .drv_o(mux_drv), .oe_o(mux_oe), .pri_in_o(mux_pri), .sec_in_o(mux_sec)
  );

  // Polarity survives power-up-clear; only the full reset clears it.
  always_ff @(posedge clk) begin
    if (rst)         pol_q <= '0;
    else if (wr_pol) pol_q <= bus_wdata;
  end

  // Control registers: power-up-clear outranks bus writes and edges.
  always_ff @(posedge clk) begin
    if (rst || puc) begin
      out_q  <= '0;
      dir_q  <= '0;
      flag_q <= '0;
      ien_q  <= '0;
      sel_q  <= '0;
      sel2_q <= '0;
      pull_q <= '0;
    end else begin
      if (wr_out)  out_q  <= bus_wdata;
      if (wr_dir)  dir_q  <= bus_wdata;
      if (wr_ien)  ien_q  <= bus_wdata;
      if (wr_sel)  sel_q  <= bus_wdata;
      if (wr_sel2) sel2_q <= bus_wdata;
      if (wr_pull) pull_q <= bus_wdata;
      flag_q <= edge_hit | (wr_flag ? bus_wdata : flag_q);
    end
  end

  always_comb begin
    rd_mux = '0;
    if      (bus_addr == ADR_IN)   rd_mux = lvl;
    else if (bus_addr == ADR_OUT)  rd_mux = out_q;
    else if (bus_addr == ADR_DIR)  rd_mux = dir_q;
    else if (bus_addr == ADR_FLAG) rd_mux = flag_q;
    else if (bus_addr == ADR_POL)  rd_mux = pol_q;
    else if (bus_addr == ADR_IEN)  rd_mux = ien_q;
    else if (bus_addr == ADR_SEL)  rd_mux = sel_q;
    else if (bus_addr == ADR_PULL) rd_mux = pull_q;
    else if (bus_addr == ADR_SEL2) rd_mux = sel2_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      pad_out   <= '0;
      pad_oe    <= '0;
      pri_in    <= '0;
      sec_in    <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      pad_out   <= mux_drv;
      pad_oe    <= mux_oe;
      pri_in    <= mux_pri;
      sec_in    <= mux_sec;
      irq       <= |(flag_q & ien_q & ~sel_q);
    end
  end

  assign pull_en = pull_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         puc,
  input logic         bus_we,
  input logic         irq,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] out_q,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] flag_q,
  input logic [W-1:0] pol_q,
  input logic [W-1:0] ien_q,
  input logic [W-1:0] sel_q,
  input logic [W-1:0] sel2_q,
  input logic [W-1:0] pull_q,
  input logic [W-1:0] edge_hit
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq && pad_oe == '0));

  // R6
  a_r6_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(flag_q & ien_q)));

  // R7
  a_r7_edge_wins: assert property (@(posedge clk) disable iff (rst)
    (|edge_hit && !puc) |=> ((flag_q & $past(edge_hit)) == $past(edge_hit)));

  // R8
  a_r8_reserved_off: assert property (@(posedge clk) disable iff (rst)
    |(sel2_q & ~sel_q) |=> ((pad_oe & $past(sel2_q & ~sel_q)) == '0));

  // R9
  a_r9_puc_clear: assert property (@(posedge clk) disable iff (rst)
    puc |=> (out_q == '0 && dir_q == '0 && flag_q == '0 && ien_q == '0 &&
             sel_q == '0 && sel2_q == '0 && pull_q == '0));

  // R9
  a_r9_pol_kept: assert property (@(posedge clk) disable iff (rst)
    (puc && !bus_we) |=> $stable(pol_q));
endmodule

bind gpio_port gpio_port_chk #(.W(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .puc(puc), .bus_we(bus_we), .irq(irq),
  .pad_oe(pad_oe), .out_q(out_q), .dir_q(dir_q), .flag_q(flag_q),
  .pol_q(pol_q), .ien_q(ien_q), .sel_q(sel_q), .sel2_q(sel2_q),
  .pull_q(pull_q), .edge_hit(edge_hit)
);

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  localparam int W = 8;
  logic clk = 1'b0, rst = 1'b1, puc = 1'b0, bus_we = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, pin_in = '0, pri_out = '0, sec_out = '0;
  logic [W-1:0] bus_rdata, pad_out, pad_oe, pull_en, pri_in, sec_in;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_port dut (
    .clk(clk), .rst(rst), .puc(puc), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en),
    .pri_out(pri_out), .sec_out(sec_out), .pri_in(pri_in), .sec_in(sec_in),
    .irq(irq)
  );

  // {address, write data, expected read}
  localparam logic [23:0] VEC [10] = '{
    {8'h21, 8'hA5, 8'hA5}, {8'h22, 8'h3C, 8'h3C}, {8'h25, 8'h81, 8'h81},
    {8'h26, 8'h0F, 8'h0F}, {8'h41, 8'hF0, 8'hF0}, {8'h27, 8'h55, 8'h55},
    {8'h24, 8'hFF, 8'hFF}, {8'h23, 8'h3C, 8'h3C}, {8'h20, 8'hFF, 8'h00},
    {8'h30, 8'h77, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pin_in = '0;
    idle(4);
    rst = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    idle(4);
    rst = 1'b0;

    // R1: reset state
    foreach (VEC[k]) begin
      rd(VEC[k][23:16], v);
      chk("R1 reset read", v, 0);
    end
    chk("R1 irq", irq, 0);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_out", pad_out, 0);

    // Table walk (R2..R12 register access)
    for (int k = 0; k < 10; k++) begin
      wr(VEC[k][23:16], VEC[k][15:8]);
      rd(VEC[k][23:16], v);
      chk("R3/R10/R12 table readback", v, VEC[k][7:0]);
    end

    // R2: plain I/O drive
    do_reset();
    wr(8'h21, 8'hA5);
    wr(8'h22, 8'hFF);
    idle(2);
    chk("R2 pad_out", pad_out, 8'hA5);
    chk("R2 pad_oe", pad_oe, 8'hFF);

    // R8: pin0 primary, pin1 secondary, pin2 reserved
    pri_out = 8'hFF; sec_out = 8'h00; pin_in = 8'hFF;
    wr(8'h26, 8'h03);
    wr(8'h41, 8'h06);
    idle(4);
    chk("R8 pad_out mux", pad_out, 8'hA1);
    chk("R8 pad_oe reserved", pad_oe, 8'hFB);
    chk("R8 pri_in", pri_in, 8'h01);
    chk("R8 sec_in", sec_in, 8'h02);

    // R3: input sampling, write ignored
    pin_in = 8'h5A;
    idle(3);
    rd(8'h20, v);
    chk("R3 input read", v, 8'h5A);
    wr(8'h20, 8'hFF);
    rd(8'h20, v);
    chk("R3 input write ignored", v, 8'h5A);

    // R4: rising edge with polarity 0
    do_reset();
    wr(8'h25, 8'hFF);
    @(negedge clk) pin_in[0] = 1'b1;
    idle(5);
    rd(8'h23, v);
    chk("R4 rise sets flag", v, 8'h01);
    chk("R6 irq on enabled flag", irq, 1);
    wr(8'h23, 8'h00);
    @(negedge clk) pin_in[0] = 1'b0;
    idle(5);
    rd(8'h23, v);
    chk("R4 fall ignored", v, 8'h00);

    // R5: falling edge with polarity 1
    wr(8'h24, 8'h02);
    @(negedge clk) pin_in[1] = 1'b1;
    idle(5);
    rd(8'h23, v);
    chk("R5 rise ignored", v, 8'h00);
    @(negedge clk) pin_in[1] = 1'b0;
    idle(5);
    rd(8'h23, v);
    chk("R5 fall sets flag", v, 8'h02);

    // R6: enable and select masking
    wr(8'h25, 8'h00);
    idle(2);
    chk("R6 irq off when disabled", irq, 0);
    wr(8'h25, 8'h02);
    idle(2);
    chk("R6 irq on", irq, 1);
    wr(8'h26, 8'h02);
    idle(2);
    chk("R6 irq masked by select", irq, 0);
    wr(8'h26, 8'h00);

    // R11: polarity write does not set flags
    wr(8'h23, 8'h00);
    wr(8'h24, 8'hFF);
    wr(8'h24, 8'h00);
    idle(3);
    rd(8'h23, v);
    chk("R11 polarity write no flag", v, 8'h00);

    // R7: software set, then hardware edge beats write of 0
    wr(8'h23, 8'h80);
    rd(8'h23, v);
    chk("R7 software set", v, 8'h80);
    wr(8'h23, 8'h00);
    rd(8'h23, v);
    chk("R7 software clear", v, 8'h00);
    @(negedge clk) pin_in[3] = 1'b1;
    @(negedge clk);
    wr(8'h23, 8'h00);
    rd(8'h23, v);
    chk("R7 edge wins over clear", v, 8'h08);

    // R9: power-up-clear subset
    wr(8'h21, 8'hFF); wr(8'h22, 8'hFF); wr(8'h25, 8'hFF);
    wr(8'h26, 8'hFF); wr(8'h41, 8'hFF); wr(8'h27, 8'hFF);
    wr(8'h24, 8'hAA); wr(8'h23, 8'hFF);
    @(negedge clk) puc = 1'b1;
    @(negedge clk) puc = 1'b0;
    foreach (VEC[k]) begin
      if (k < 8 && VEC[k][23:16] != 8'h24) begin
        rd(VEC[k][23:16], v);
        chk("R9 puc clears", v, 0);
      end
    end
    rd(8'h24, v);
    chk("R9 polarity kept", v, 8'hAA);

    // R10: pull enable output
    wr(8'h27, 8'h5A);
    idle(1);
    chk("R10 pull_en", pull_en, 8'h5A);
    rd(8'h27, v);
    chk("R10 readback", v, 8'h5A);

    // R12: unmapped address
    rd(8'h30, v);
    chk("R12 unmapped", v, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule